// File: doc/BRIEF.md
# Coulomb Charge and Time Integrator

This block totals the charge that has passed through a battery pack. Signed 16-bit current samples arrive at a slow fixed rate, one every 250 ms in normal operation, and each comes with a single-cycle valid strobe. The block multiplies each accepted sample by a programmable unsigned gain. The gain is a 0.32 fraction equal to the sample period divided by the charge unit. The block sign-extends the product and adds it into a signed 64-bit total. The upper 32 bits of the total are whole charge units and the lower 32 bits are the fraction. A positive sample means charging current and raises the total. A negative sample means discharging current and lowers it.

The block also counts elapsed integration time in whole seconds. A two-bit phase counter advances on every accepted sample and rolls over every fourth one, and each rollover adds one second. The host clears the total, the seconds count and the phase with a single command strobe. The host reads through a shadow set of three words (integer part, fraction part, seconds). A snapshot strobe loads all three at once, so a read that spans several words always sees values from the same moment.

Top module: `coulomb_integrator`

## Requirements
- R1: After reset, the integer, fraction and seconds read words are all zero, and so are the internal total, seconds count and phase.
- R2: On each clock with `smp_valid` high, the total increases by the signed sample times the unsigned 0.32 gain. The product is a signed value in units of 2^-32 charge units, sign-extended to 64 bits. Read bits [63:32] of the total as `rd_whole` and bits [31:0] as `rd_part`.
- R3: A negative sample lowers the total. For example, 1.25 followed by sample -8 at gain 0.25 reads whole 0xFFFFFFFF and part 0x40000000.
- R4: On a clock with `smp_valid` low and no clear, the total, seconds and phase do not change, whatever `smp_data` holds.
- R5: The total wraps in 64-bit two's complement. From zero, sample -1 at gain 1 reads all ones in both words.
- R6: The seconds count rises by exactly one on every fourth accepted sample after reset or clear, and does not change on the other samples.
- R7: The seconds count saturates at all ones and stays there as further samples are accepted.
- R8: A `clr_cmd` pulse zeroes the total, the seconds count and the phase on that edge. When it arrives on the same edge as a sample, the clear wins and the sample is discarded.
- R9: The read words change only on an edge where `snap_req` is high. They then take the total and seconds as they stood before that edge's own sample or clear, and hold that value until the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | Single-cycle strobe that accepts `smp_data` |
| smp_data | input | 16 | Signed current sample, positive for charging |
| gain | input | 32 | Unsigned 0.32 scale factor, sample period over charge unit |
| clr_cmd | input | 1 | Host command that clears the total, the seconds and the phase |
| snap_req | input | 1 | Loads the three read words from the live state |
| rd_whole | output | 32 | Snapshot of the integer part of the total |
| rd_part | output | 32 | Snapshot of the fraction part of the total |
| rd_secs | output | 32 | Snapshot of the elapsed seconds |

## Verification
The hardest condition to reach from the ports is seconds saturation. At four samples per second, a 32-bit count would need about 2^34 samples to saturate. The bench therefore builds a second copy of the block with a 3-bit seconds width and drives it past 28 samples to show the count stop at 7. The same-edge cases are reached by driving strobes together on one edge: clear with a sample, snapshot with a sample, and snapshot with a clear. Each is checked against a bench model that updates after recording the pre-edge value.

// File: rtl/ci_pkg.sv
package ci_pkg;
  parameter int unsigned CI_SAMPLE_W   = 16;
  parameter int unsigned CI_GAIN_W     = 32;
  parameter int unsigned CI_WHOLE_W    = 32;
  parameter int unsigned CI_FRAC_W     = 32;
  parameter int unsigned CI_TIME_W     = 32;
  parameter int unsigned CI_SMP_PER_S  = 4;

  function automatic int unsigned ci_phase_w(input int unsigned per_s);
    return (per_s > 1) ? $clog2(per_s) : 1;
  endfunction
endpackage

// File: rtl/ci_scaler.sv
module ci_scaler #(
  parameter int unsigned SAMPLE_W = ci_pkg::CI_SAMPLE_W,
  parameter int unsigned GAIN_W   = ci_pkg::CI_GAIN_W,
  parameter int unsigned ACC_W    = ci_pkg::CI_WHOLE_W + ci_pkg::CI_FRAC_W
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [GAIN_W-1:0]   gain_i,
  output logic [ACC_W-1:0]    delta_o
);
  localparam int unsigned PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] smp_ext;
  logic signed [PROD_W-1:0] gain_ext;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    smp_ext  = PROD_W'($signed(sample_i));
    gain_ext = $signed({{(PROD_W-GAIN_W){1'b0}}, gain_i});
    prod     = smp_ext * gain_ext;
  end

  generate
    if (ACC_W > PROD_W) begin : g_extend
      assign delta_o = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign delta_o = prod[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ci_charge_acc.sv
module ci_charge_acc #(
  parameter int unsigned ACC_W = ci_pkg::CI_WHOLE_W + ci_pkg::CI_FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] delta_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = clr_i | en_i;
    if (clr_i) acc_d = '0;
    else       acc_d = acc_q + delta_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ci_sec_timer.sv
module ci_sec_timer #(
  parameter int unsigned SMP_PER_S = ci_pkg::CI_SMP_PER_S,
  parameter int unsigned TIME_W    = ci_pkg::CI_TIME_W,
  parameter int unsigned PH_W      = ci_pkg::ci_phase_w(SMP_PER_S)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  output logic [TIME_W-1:0] secs_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(SMP_PER_S - 1);
  localparam logic [TIME_W-1:0] SECS_MAX = '1;

  logic [PH_W-1:0]   phase_q, phase_d;
  logic [TIME_W-1:0] secs_q, secs_d;
  logic              tmr_en;

  always_comb begin
    tmr_en  = clr_i | en_i;
    phase_d = phase_q;
    secs_d  = secs_q;
    if (clr_i) begin
      phase_d = '0;
      secs_d  = '0;
    end else if (phase_q == PH_LAST) begin
      phase_d = '0;
      if (secs_q != SECS_MAX) secs_d = secs_q + 1'b1;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      secs_q  <= '0;
    end else if (tmr_en) begin
      phase_q <= phase_d;
      secs_q  <= secs_d;
    end
  end

  assign secs_o  = secs_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/coulomb_integrator.sv
module coulomb_integrator #(
  parameter int unsigned SAMPLE_W  = ci_pkg::CI_SAMPLE_W,
  parameter int unsigned GAIN_W    = ci_pkg::CI_GAIN_W,
  parameter int unsigned WHOLE_W   = ci_pkg::CI_WHOLE_W,
  parameter int unsigned FRAC_W    = ci_pkg::CI_FRAC_W,
  parameter int unsigned TIME_W    = ci_pkg::CI_TIME_W,
  parameter int unsigned SMP_PER_S = ci_pkg::CI_SMP_PER_S
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [GAIN_W-1:0]   gain,
  input  logic                clr_cmd,
  input  logic                snap_req,
  output logic [WHOLE_W-1:0]  rd_whole,
  output logic [FRAC_W-1:0]   rd_part,
  output logic [TIME_W-1:0]   rd_secs
);
  localparam int unsigned ACC_W = WHOLE_W + FRAC_W;
  localparam int unsigned PH_W  = ci_pkg::ci_phase_w(SMP_PER_S);

  logic       rst_meta_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [ACC_W-1:0]  delta;
  logic [ACC_W-1:0]  acc;
  logic [TIME_W-1:0] secs;
  logic [PH_W-1:0]   phase;

  ci_scaler #(
    .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W)
  ) u_scaler (
    .sample_i(smp_data), .gain_i(gain), .delta_o(delta)
  );

  ci_charge_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr_cmd), .en_i(smp_valid),
    .delta_i(delta), .acc_o(acc)
  );

  ci_sec_timer #(
    .SMP_PER_S(SMP_PER_S), .TIME_W(TIME_W), .PH_W(PH_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr_cmd), .en_i(smp_valid),
    .secs_o(secs), .phase_o(phase)
  );

  logic [WHOLE_W-1:0] whole_q, whole_d;
  logic [FRAC_W-1:0]  part_q, part_d;
  logic [TIME_W-1:0]  secs_sh_q, secs_sh_d;

  always_comb begin
    whole_d   = acc[ACC_W-1:FRAC_W];
    part_d    = acc[FRAC_W-1:0];
    secs_sh_d = secs;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      whole_q   <= '0;
      part_q    <= '0;
      secs_sh_q <= '0;
    end else if (snap_req) begin
      whole_q   <= whole_d;
      part_q    <= part_d;
      secs_sh_q <= secs_sh_d;
    end
  end

  assign rd_whole = whole_q;
  assign rd_part  = part_q;
  assign rd_secs  = secs_sh_q;
endmodule

// File: rtl/coulomb_integrator_chk.sv
module coulomb_integrator_chk #(
  parameter int unsigned ACC_W   = 64,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned TIME_W  = 32,
  parameter int unsigned PH_W    = 2,
  parameter int unsigned PH_LAST = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              smp_valid,
  input logic              clr_cmd,
  input logic              snap_req,
  input logic [ACC_W-1:0]  delta,
  input logic [ACC_W-1:0]  acc,
  input logic [TIME_W-1:0] secs,
  input logic [PH_W-1:0]   phase,
  input logic [ACC_W-FRAC_W-1:0] rd_whole,
  input logic [FRAC_W-1:0] rd_part,
  input logic [TIME_W-1:0] rd_secs
);
  localparam logic [TIME_W-1:0] SMAX = '1;

  a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && !clr_cmd) |=> acc == $past(acc) + $past(delta));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!smp_valid && !clr_cmd) |=> ($stable(acc) && $stable(secs) && $stable(phase)));

  a_r6_second_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && !clr_cmd && phase == PH_W'(PH_LAST) && secs != SMAX)
      |=> secs == $past(secs) + 1'b1);

  a_r6_no_midstep: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_cmd && phase != PH_W'(PH_LAST)) |=> $stable(secs));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_cmd && secs == SMAX) |=> secs == SMAX);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_cmd |=> (acc == '0 && secs == '0 && phase == '0));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snap_req |=> ({rd_whole, rd_part} == $past(acc) && rd_secs == $past(secs)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !snap_req |=> ($stable(rd_whole) && $stable(rd_part) && $stable(rd_secs)));
endmodule

bind coulomb_integrator coulomb_integrator_chk #(
  .ACC_W(ACC_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W), .PH_W(PH_W),
  .PH_LAST(SMP_PER_S - 1)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .smp_valid(smp_valid),
  .clr_cmd(clr_cmd), .snap_req(snap_req), .delta(delta), .acc(acc),
  .secs(secs), .phase(phase), .rd_whole(rd_whole), .rd_part(rd_part),
  .rd_secs(rd_secs)
);

// File: tb/coulomb_integrator_tb_top.sv
module coulomb_integrator_tb_top;
  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic [31:0] gain;
  logic        clr_cmd;
  logic        snap_req;
  logic [31:0] rd_whole, rd_part, rd_secs;

  logic        sat_valid, sat_snap;
  logic [31:0] sat_whole, sat_part;
  logic [2:0]  sat_secs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  coulomb_integrator dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .gain(gain), .clr_cmd(clr_cmd), .snap_req(snap_req),
    .rd_whole(rd_whole), .rd_part(rd_part), .rd_secs(rd_secs)
  );

  coulomb_integrator #(.TIME_W(3)) sat_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(sat_valid), .smp_data(smp_data),
    .gain(gain), .clr_cmd(clr_cmd), .snap_req(sat_snap),
    .rd_whole(sat_whole), .rd_part(sat_part), .rd_secs(sat_secs)
  );

  // bench-side model
  logic [63:0] m_acc;
  logic [31:0] m_secs;
  int          m_phase;

  logic [63:0] exp_acc_q[$];
  logic [31:0] exp_secs_q[$];
  string       exp_tag_q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // driver: one clock of stimulus, scoreboard push on snapshot, model update
  task automatic step(input bit v, input logic [15:0] d, input bit c, input bit s, input string tag);
    logic signed [63:0] prod;
    @(negedge clk);
    smp_valid = v; smp_data = d; clr_cmd = c; snap_req = s;
    if (s) begin
      exp_acc_q.push_back(m_acc);
      exp_secs_q.push_back(m_secs);
      exp_tag_q.push_back(tag);
    end
    if (c) begin
      m_acc = '0; m_secs = '0; m_phase = 0;
    end else if (v) begin
      prod  = 64'(signed'(d)) * $signed({32'b0, gain});
      m_acc = m_acc + prod;
      m_phase++;
      if (m_phase == 4) begin
        m_phase = 0;
        if (m_secs != 32'hFFFF_FFFF) m_secs++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'hA5A5, 1'b0, 1'b0, "");
  endtask

  task automatic snap(input string tag);
    step(1'b0, 16'h0, 1'b0, 1'b1, tag);
    idle(1);
  endtask

  // monitor: compare read words after each snapshot edge
  initial begin
    forever begin
      @(posedge clk);
      if (snap_req && rst_n) begin
        logic [63:0] ea;
        logic [31:0] es;
        string       t;
        @(negedge clk);
        ea = exp_acc_q.pop_front();
        es = exp_secs_q.pop_front();
        t  = exp_tag_q.pop_front();
        check({t, " whole"}, 64'(rd_whole), 64'(ea[63:32]));
        check({t, " part"},  64'(rd_part),  64'(ea[31:0]));
        check({t, " secs"},  64'(rd_secs),  64'(es));
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 0; smp_data = 0; gain = 0;
    clr_cmd = 0; snap_req = 0; sat_valid = 0; sat_snap = 0;
    m_acc = 0; m_secs = 0; m_phase = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state at the ports
    check("R1 whole", 64'(rd_whole), 64'h0);
    check("R1 part",  64'(rd_part),  64'h0);
    check("R1 secs",  64'(rd_secs),  64'h0);
    snap("R1 snap");

    // R2 scaling: gain 0.25
    gain = 32'h4000_0000;
    step(1, 16'd4, 0, 0, "");
    snap("R2 one unit");
    step(1, 16'd1, 0, 0, "");
    snap("R2 quarter");
    // R3 discharge lowers total: 1.25 - 2 = -0.75
    step(1, 16'hFFF8, 0, 0, "");
    snap("R3 negative");
    // R4 idle with noise on data
    idle(6);
    snap("R4 idle");
    // R9 outputs hold without snapshot while samples land
    step(1, 16'd100, 0, 0, "");
    step(1, 16'd7, 0, 0, "");
    idle(1);
    check("R9 hold whole", 64'(rd_whole), 64'hFFFF_FFFF);
    check("R9 hold part",  64'(rd_part),  64'h4000_0000);
    // R6 seconds on every fourth sample (5 accepted so far)
    snap("R6 after five");
    step(1, 16'd3, 0, 0, ""); step(1, 16'd3, 0, 0, "");
    snap("R6 after seven");
    step(1, 16'd3, 0, 0, "");
    snap("R6 after eight");
    // R9 snapshot and sample on the same edge
    step(1, 16'd40, 0, 1, "R9 snap with sample");
    idle(1);
    snap("R9 after");
    // R8 clear with coincident sample
    step(1, 16'd999, 1, 0, "");
    snap("R8 clear wins");
    // R8 phase cleared: three samples after clear give no second
    gain = 32'h1234_5678;
    step(1, 16'h7FFF, 0, 0, ""); step(1, 16'h8000, 0, 0, ""); step(1, 16'd5, 0, 0, "");
    snap("R8 phase cleared");
    step(1, 16'd5, 0, 0, "");
    snap("R6 first second");
    // R9 snapshot with clear on same edge sees pre-clear state
    step(0, 16'd0, 1, 1, "R9 snap with clear");
    idle(1);
    snap("R8 after clear");
    // R5 wrap below zero
    gain = 32'h0000_0001;
    step(1, 16'hFFFF, 0, 0, "");
    snap("R5 all ones");
    gain = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) step(1, 16'h8000, 0, 0, "");
    snap("R5 large negative");
    for (int i = 0; i < 9; i++) step(1, 16'h7FFF, 0, 0, "");
    snap("R5 mixed");
    idle(3);

    // R7 saturation on the 3-bit seconds copy (clear from above already applied)
    step(0, 16'd0, 1, 0, "");
    idle(1);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); sat_valid = 1;
    end
    @(negedge clk); sat_valid = 0; sat_snap = 1;
    @(negedge clk); sat_snap = 0;
    check("R7 six seconds", 64'(sat_secs), 64'd6);
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); sat_valid = 1;
    end
    @(negedge clk); sat_valid = 0; sat_snap = 1;
    @(negedge clk); sat_snap = 0;
    check("R7 saturated", 64'(sat_secs), 64'd7);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sat_valid = 1;
    end
    @(negedge clk); sat_valid = 0; sat_snap = 1;
    @(negedge clk); sat_snap = 0;
    check("R7 still saturated", 64'(sat_secs), 64'd7);

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule